// File: doc/BRIEF.md
# Single-Bus Hardwired Control Sequencer

This block is the control and datapath core of a small processor whose registers all share one bus. A step counter, combined with the decoded opcode in the instruction register, produces every control strobe for each cycle. These strobes cover which register drives the bus, which registers load from it, which operation the ALU performs, whether the second ALU input is the Y register or the constant four, and when a memory read is requested. The ALU never drives the bus. Its result is captured in a Z register, and a later step places Z on the bus.

The unit fetches an instruction, adds two general registers, and jumps relative to the program counter. Any other opcode returns directly to fetch. Memory is external. The core presents the address held in its memory address register, raises a read request, and holds its step until memory signals completion. The word it receives is staged in a data register and then copied into the instruction register. The bus value, the bus-driver vector, the flags and the step number are brought out so that each transfer can be observed.

Top module: `sbus_ctl_core`

## Requirements
- R1: In every cycle at most one bus driver is enabled. The bits of `bus_drv` are: bit 0 PC, bit 1 Z, bit 2 memory data register, bit 3 sign-extended IR offset, bit 4+k general register k.
- R2: During and straight after reset the step is 0, PC and `mem_addr` are 0, the flags are 0, `mem_rd` is low, and general register k holds k * 32'h1111_1111.
- R3: In step 0 the PC drives the bus and loads the address register. Z captures the PC plus the constant four. In step 1 Z drives the bus (value PC+4) and loads the PC.
- R4: `mem_rd` is high in steps 1 and 2, with `mem_addr` equal to the fetched PC. The step stays at 2 until a cycle in which `mem_mfc` is high, and step 2 lasts at least one cycle.
- R5: In step 3 the data register drives the bus with the word captured when `mem_mfc` was high, and that word is loaded into IR.
- R6: The instruction word holds the opcode in bits [31:28], rd in [27:24], rs1 in [23:20], rs2 in [19:16] and a signed byte offset in [15:0]. Register fields use their low 3 bits. For opcode 1 (ADD), step 4 drives rs1 into Y and step 5 drives rs2 while Z captures Y+rs2. Step 6 drives Z, and rd loads the 32-bit sum.
- R7: Flags are {Z,N,V,C} in bits [3:0] as 3..0. They are updated only by the ADD sum and stay unchanged through fetch, jump and undefined opcodes. Z means the sum is zero, N is the sum's top bit, V is signed overflow and C is the unsigned carry out.
- R8: For opcode 2 (jump), step 4 drives the sign-extended offset into Y and step 5 drives the incremented PC while Z captures their sum. Step 6 drives Z into the PC, so the next fetch address is PC+4+offset.
- R9: Any other opcode leaves step 4 with no bus driver and goes to step 0 on the next cycle. No register or flag changes, and the next fetch is at PC+4.
- R10: Steps run 0,1,2,3,4 and then, for ADD and jump, 5,6. After step 6 the next step is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Word returned by memory |
| mem_mfc | input | 1 | Memory function complete; `mem_rdata` valid |
| mem_addr | output | 32 | Byte address held in the address register |
| mem_rd | output | 1 | Memory read request |
| bus_val | output | 32 | Value on the shared bus this cycle |
| bus_drv | output | 12 | Enabled bus drivers (R1 bit order) |
| flags | output | 4 | {Z,N,V,C} from the last ADD |
| step | output | 3 | Current timing step 0..6 |

## Verification
The assertions assume that memory raises `mem_mfc` only while `mem_rd` is high, and that `mem_rdata` is valid in any cycle in which `mem_mfc` is high. The stall check also assumes completion eventually arrives. The bench memory model drives `mem_mfc` only during an outstanding read. It drops the signal once the request goes low, and it varies the completion delay from zero to three cycles across fetches. The program contains forward and backward jumps, an undefined opcode, a destination equal to its source, and sums that produce zero, overflow and carry.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 8;
  localparam int RIDX_W  = $clog2(NREG);
  localparam int NFIX    = 4;
  localparam int NDRV    = NFIX + NREG;
  localparam int FLAG_W  = 4;
  localparam int OPC_W   = 4;
  localparam int OPC_LSB = 28;
  localparam int RD_LSB  = 24;
  localparam int RS1_LSB = 20;
  localparam int RS2_LSB = 16;
  localparam int OFF_W   = 16;

  localparam int DRV_PC  = 0;
  localparam int DRV_Z   = 1;
  localparam int DRV_MDR = 2;
  localparam int DRV_OFF = 3;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'h2;

  typedef enum logic [2:0] {
    ST_F0   = 3'd0,
    ST_F1   = 3'd1,
    ST_WAIT = 3'd2,
    ST_IRLD = 3'd3,
    ST_X1   = 3'd4,
    ST_X2   = 3'd5,
    ST_X3   = 3'd6
  } step_e;

  typedef enum logic {ALU_IDLE = 1'b0, ALU_ADD = 1'b1} alu_op_e;

  typedef struct packed {
    logic [NREG-1:0] r_out;
    logic [NREG-1:0] r_in;
    logic [NFIX-1:0] fix_out;
    logic            mar_in;
    logic            pc_in;
    logic            ir_in;
    logic            y_in;
    logic            z_in;
    logic            use_four;
    logic            flag_en;
    logic            mem_rd;
    alu_op_e         alu;
  } ctl_t;

  function automatic logic [XLEN:0] alu_add(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [FLAG_W-1:0] alu_flags(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic [XLEN:0] s;
    logic zf, nf, vf, cf;
    s  = alu_add(a, b);
    zf = (s[XLEN-1:0] == '0);
    nf = s[XLEN-1];
    vf = (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
    cf = s[XLEN];
    return {zf, nf, vf, cf};
  endfunction

  function automatic logic [XLEN-1:0] seed_val(input int k);
    return XLEN'(k) * {(XLEN/4){4'h1}};
  endfunction

  function automatic logic [XLEN-1:0] sext_off(input logic [XLEN-1:0] ir);
    return {{(XLEN-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
  import sbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] ir_i,
  input  logic            mem_mfc,
  output step_e           step_o,
  output ctl_t            ctl_o
);
  step_e step_q, step_nx;

  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] rd_i, rs1_i, rs2_i;
  logic              is_add, is_jmp;
  logic              unused_ir_bits;

  assign opc    = ir_i[OPC_LSB +: OPC_W];
  assign rd_i   = ir_i[RD_LSB  +: RIDX_W];
  assign rs1_i  = ir_i[RS1_LSB +: RIDX_W];
  assign rs2_i  = ir_i[RS2_LSB +: RIDX_W];
  assign is_add = (opc == OPC_ADD);
  assign is_jmp = (opc == OPC_JMP);
  assign unused_ir_bits = ^{ir_i[OFF_W-1:0], ir_i[OPC_LSB-1:RD_LSB+RIDX_W],
                            ir_i[RD_LSB-1:RS1_LSB+RIDX_W], ir_i[RS1_LSB-1:RS2_LSB+RIDX_W]};

  always_comb begin
    case (step_q)
      ST_F0:   step_nx = ST_F1;
      ST_F1:   step_nx = ST_WAIT;
      ST_WAIT: step_nx = mem_mfc ? ST_IRLD : ST_WAIT;
      ST_IRLD: step_nx = ST_X1;
      ST_X1:   step_nx = (is_add || is_jmp) ? ST_X2 : ST_F0;
      ST_X2:   step_nx = ST_X3;
      default: step_nx = ST_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_F0;
    else        step_q <= step_nx;
  end

  always_comb begin
    ctl_o     = '0;
    ctl_o.alu = ALU_IDLE;
    case (step_q)
      ST_F0: begin
        ctl_o.fix_out[DRV_PC] = 1'b1;
        ctl_o.mar_in   = 1'b1;
        ctl_o.use_four = 1'b1;
        ctl_o.alu      = ALU_ADD;
        ctl_o.z_in     = 1'b1;
      end
      ST_F1: begin
        ctl_o.fix_out[DRV_Z] = 1'b1;
        ctl_o.pc_in  = 1'b1;
        ctl_o.mem_rd = 1'b1;
      end
      ST_WAIT: ctl_o.mem_rd = 1'b1;
      ST_IRLD: begin
        ctl_o.fix_out[DRV_MDR] = 1'b1;
        ctl_o.ir_in = 1'b1;
      end
      ST_X1: begin
        if (is_add) begin
          ctl_o.r_out[rs1_i] = 1'b1;
          ctl_o.y_in = 1'b1;
        end else if (is_jmp) begin
          ctl_o.fix_out[DRV_OFF] = 1'b1;
          ctl_o.y_in = 1'b1;
        end
      end
      ST_X2: begin
        if (is_add) begin
          ctl_o.r_out[rs2_i] = 1'b1;
          ctl_o.flag_en = 1'b1;
        end else begin
          ctl_o.fix_out[DRV_PC] = 1'b1;
        end
        ctl_o.alu  = ALU_ADD;
        ctl_o.z_in = 1'b1;
      end
      ST_X3: begin
        ctl_o.fix_out[DRV_Z] = 1'b1;
        if (is_add) ctl_o.r_in[rd_i] = 1'b1;
        else        ctl_o.pc_in = 1'b1;
      end
      default: ;
    endcase
  end

  assign step_o = step_q;

  // R1
  one_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_o.r_out, ctl_o.fix_out}));

  // R4
  mfc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_WAIT && !mem_mfc) |=> (step_q == ST_WAIT));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_X3) |=> (step_q == ST_F0));
endmodule

// File: rtl/sbus_regs.sv
module sbus_regs
  import sbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] bus_i,
  input  logic [NREG-1:0] r_in,
  input  logic [NREG-1:0] r_out,
  output logic [XLEN-1:0] drive_o
);
  logic [XLEN-1:0] gated [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= seed_val(k);
      else if (r_in[k])  q <= bus_i;
    end
    assign gated[k] = r_out[k] ? q : '0;
  end

  always_comb begin
    drive_o = '0;
    for (int k = 0; k < NREG; k++) drive_o = drive_o | gated[k];
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   bus_i,
  input  logic [XLEN-1:0]   y_i,
  input  logic              use_four,
  input  alu_op_e           op,
  input  logic              z_in,
  input  logic              flag_en,
  output logic [XLEN-1:0]   z_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [XLEN-1:0] opnd_b;
  logic [XLEN:0]   sum_w;

  assign opnd_b = use_four ? XLEN'(4) : y_i;
  assign sum_w  = (op == ALU_ADD) ? alu_add(bus_i, opnd_b) : {1'b0, bus_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_o     <= '0;
      flags_o <= '0;
    end else begin
      if (z_in)    z_o     <= sum_w[XLEN-1:0];
      if (flag_en) flags_o <= alu_flags(bus_i, opnd_b);
    end
  end

  // R7
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(flags_o));
endmodule

// File: rtl/sbus_ctl_core.sv
module sbus_ctl_core
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_mfc,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_rd,
  output logic [XLEN-1:0]   bus_val,
  output logic [NDRV-1:0]   bus_drv,
  output logic [FLAG_W-1:0] flags,
  output logic [2:0]        step
);
  ctl_t            ctl;
  step_e           cur_step;
  logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
  logic [XLEN-1:0] reg_drive, bus;
  logic            mdr_capture;

  assign mdr_capture = (cur_step == ST_WAIT) && mem_mfc;

  sbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ir_i(ir_q), .mem_mfc(mem_mfc),
    .step_o(cur_step), .ctl_o(ctl)
  );

  sbus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_i(bus), .r_in(ctl.r_in),
    .r_out(ctl.r_out), .drive_o(reg_drive)
  );

  sbus_alu u_alu (
    .clk(clk), .rst_n(rst_n), .bus_i(bus), .y_i(y_q), .use_four(ctl.use_four),
    .op(ctl.alu), .z_in(ctl.z_in), .flag_en(ctl.flag_en), .z_o(z_q), .flags_o(flags)
  );

  always_comb begin
    bus = reg_drive;
    if (ctl.fix_out[DRV_PC])  bus = bus | pc_q;
    if (ctl.fix_out[DRV_Z])   bus = bus | z_q;
    if (ctl.fix_out[DRV_MDR]) bus = bus | mdr_q;
    if (ctl.fix_out[DRV_OFF]) bus = bus | sext_off(ir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      y_q   <= '0;
    end else begin
      if (ctl.pc_in)  pc_q  <= bus;
      if (ctl.mar_in) mar_q <= bus;
      if (mdr_capture) mdr_q <= mem_rdata;
      if (ctl.ir_in)  ir_q  <= bus;
      if (ctl.y_in)   y_q   <= bus;
    end
  end

  assign mem_addr = mar_q;
  assign mem_rd   = ctl.mem_rd;
  assign bus_val  = bus;
  assign bus_drv  = {ctl.r_out, ctl.fix_out};
  assign step     = cur_step;

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step == ST_WAIT && $past(cur_step) == ST_F1) |-> (pc_q == $past(pc_q) + XLEN'(4)));

  // R5
  ir_after_mfc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step == ST_IRLD) |-> $past(mem_mfc));

  // R4
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step == ST_WAIT) |-> (mem_rd && mar_q == pc_q - XLEN'(4)));
endmodule

// File: tb/sbus_ctl_core_bench.sv
`timescale 1ns/1ps
module sbus_ctl_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_mfc = 1'b0;
  logic [31:0] mem_addr, bus_val;
  logic        mem_rd;
  logic [11:0] bus_drv;
  logic [3:0]  flags;
  logic [2:0]  step;

  int checks = 0;
  int fails = 0;
  int multi_drv = 0;
  int cur_lat = 0;
  int rd_cnt = 0;
  logic [31:0] mem [0:63];
  logic [31:0] regs [0:7];
  logic [31:0] pc;
  logic [3:0]  exp_flags;

  always #2.5 clk = ~clk;

  sbus_ctl_core u_sbus_ctl_core (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .bus_val(bus_val), .bus_drv(bus_drv),
    .flags(flags), .step(step)
  );

  // memory model with a variable completion delay
  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      mem_mfc   = (rd_cnt >= cur_lat);
      mem_rdata = mem[mem_addr[7:2]];
      rd_cnt++;
    end else begin
      mem_mfc = 1'b0;
      rd_cnt  = 0;
    end
    if (rst_n && $countones(bus_drv) > 1) multi_drv++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_add(input int rd, input int rs1, input int rs2);
    return {4'h1, 4'(rd), 4'(rs1), 4'(rs2), 16'h0};
  endfunction

  function automatic logic [31:0] enc_jmp(input int off);
    return {4'h2, 12'h0, 16'(off)};
  endfunction

  task automatic run_one(input int n);
    logic [31:0] w, a, b, sum, pc_nx, off, tgt;
    longint ssum;
    int waits, lat, rd, rs1, rs2;
    lat = n % 4;
    cur_lat = lat;
    chk(step == 3'd0, "R10 step0", 32'(step), 0);
    chk(bus_drv == 12'h001 && bus_val == pc, "R3 PC drives bus", bus_val, pc);
    @(negedge clk);
    chk(step == 3'd1 && bus_drv == 12'h002 && bus_val == pc + 4, "R3 Z holds PC+4", bus_val, pc + 4);
    chk(mem_rd && mem_addr == pc, "R4 fetch address", mem_addr, pc);
    waits = 0;
    @(negedge clk);
    while (step == 3'd2 && waits < 20) begin waits++; @(negedge clk); end
    chk(waits == ((lat < 1) ? 1 : lat), "R4 wait length", 32'(waits), 32'((lat < 1) ? 1 : lat));
    w = mem[pc[7:2]];
    chk(step == 3'd3 && bus_drv == 12'h004 && bus_val == w, "R5 fetched word on bus", bus_val, w);
    pc_nx = pc + 4;
    @(negedge clk);
    rd = int'(w[26:24]); rs1 = int'(w[22:20]); rs2 = int'(w[18:16]);
    if (w[31:28] == 4'h1) begin
      a = regs[rs1]; b = regs[rs2];
      chk(bus_drv == 12'(1 << (4 + rs1)) && bus_val == a, "R6 rs1 read", bus_val, a);
      @(negedge clk);
      chk(step == 3'd5 && bus_val == b, "R6 rs2 read", bus_val, b);
      @(negedge clk);
      sum  = a + b;
      ssum = longint'($signed(a)) + longint'($signed(b));
      exp_flags = {sum == 0, sum[31], (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648),
                   ({32'h0, a} + {32'h0, b}) > 64'hFFFF_FFFF};
      chk(step == 3'd6 && bus_drv == 12'h002 && bus_val == sum, "R6 sum write back", bus_val, sum);
      regs[rd] = sum;
      pc = pc_nx;
      @(negedge clk);
      chk(flags == exp_flags, "R7 flags after ADD", 32'(flags), 32'(exp_flags));
    end else if (w[31:28] == 4'h2) begin
      off = {{16{w[15]}}, w[15:0]};
      chk(bus_drv == 12'h008 && bus_val == off, "R8 offset on bus", bus_val, off);
      @(negedge clk);
      chk(step == 3'd5 && bus_val == pc_nx, "R8 PC to ALU", bus_val, pc_nx);
      @(negedge clk);
      tgt = pc_nx + off;
      chk(step == 3'd6 && bus_val == tgt, "R8 jump target", bus_val, tgt);
      pc = tgt;
      @(negedge clk);
      chk(flags == exp_flags, "R7 flags kept by jump", 32'(flags), 32'(exp_flags));
    end else begin
      chk(step == 3'd4 && bus_drv == 12'h000, "R9 idle step", 32'(bus_drv), 0);
      @(negedge clk);
      chk(step == 3'd0 && flags == exp_flags, "R9 return to fetch", 32'(step), 0);
      pc = pc_nx;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = enc_add(6, 6, 6);
    mem[0]  = enc_add(1, 2, 3);
    mem[1]  = enc_add(7, 7, 7);
    mem[2]  = enc_add(7, 7, 7);
    mem[3]  = 32'hF123_4567;
    mem[4]  = enc_add(0, 0, 0);
    mem[5]  = enc_jmp(12);
    mem[9]  = enc_add(4, 1, 7);
    mem[10] = enc_jmp(-44);
    for (int k = 0; k < 8; k++) regs[k] = 32'(k) * 32'h1111_1111;
    pc = 0;
    exp_flags = 0;
    repeat (3) @(negedge clk);
    // R2
    chk(step == 3'd0 && mem_addr == 0 && !mem_rd, "R2 reset step/addr", mem_addr, 0);
    chk(flags == 4'h0 && bus_val == 0, "R2 reset flags/PC", 32'(flags), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 40; n++) run_one(n);
    chk(multi_drv == 0, "R1 single bus driver", 32'(multi_drv), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule